// File: doc/BRIEF.md
# Receive Elastic Store with Controlled Frame Slip

This block moves received PCM frames of 32 eight-bit channels from the clock recovered from the line into the local backplane clock. It holds two frames (64 channels, 512 bits). The line side writes one byte per channel strobe. The backplane side reads one byte per channel strobe. The write side advances its own channel pointer. A Gray-coded copy of that pointer crosses into the read clock, and the read side measures how many channels the read pointer trails the write pointer, modulo 64.

When the two clocks drift apart, that trailing distance drifts too. The distance is only checked when the read pointer is about to read channel 0 of a frame. If the distance has fallen to the low mark (2 channels or less), the read pointer steps back one frame, so the previous frame is read again. If the distance has grown to the high mark (60 channels or more), the read pointer steps forward one frame, so one frame is discarded. Either slip moves the distance by exactly 32 channels: a slip at 2 leaves 34, and a slip at 60 leaves 28. Every slip inverts a toggle output and records its direction. It also sets a pending interrupt that a mask input can hide and an acknowledge input clears.

Top module: `rx_elastic_slip`

## Requirements
- R1: After reset the read pointer sits 32 channels behind the write pointer (write pointer 0, read pointer 32), so the first frame boundary sees a distance of 32 and does not slip. `rd_data`, `slip_tog`, `slip_dir` and `slip_irq` are 0 after reset.
- R2: Each `wr_en` cycle stores `wr_data` at the write pointer and then advances the pointer modulo 64. Each `rd_en` cycle places the byte at the read pointer on `rd_data` one `rclk` edge later and then advances the pointer. Writes that ended at least 8 `rclk` cycles earlier are visible to the read side.
- R3: The distance is the synchronized write pointer minus the read pointer, modulo 64. It is evaluated only on a read whose read pointer has its low 5 bits equal to 0, which is channel 0 of a frame.
- R4: If the distance at a frame boundary is 2 or less, the read pointer moves back 32 channels before the read, and the previous frame is repeated (a distance of 2 becomes 34).
- R5: If the distance at a frame boundary is 60 or more, the read pointer moves forward 32 channels before the read, and one frame is dropped (a distance of 60 becomes 28).
- R6: A boundary distance from 3 to 59 inclusive causes no slip.
- R7: No slip happens on a read of channels 1 to 31, however close or far the pointers are.
- R8: `slip_tog` inverts on the same `rclk` edge as each slip, and at no other time.
- R9: `slip_dir` becomes 1 on a repeating slip and 0 on a dropping slip. It holds until the next slip.
- R10: A slip sets a pending flag. `slip_irq` equals pending AND NOT `irq_mask`. Pending stays set while masked. An `irq_ack` cycle clears it, unless a slip occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-recovered write clock |
| wrst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write strobe, one per channel |
| wr_data | input | 8 | Channel byte to store |
| rclk | input | 1 | Backplane read clock |
| rrst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Read strobe, one per channel |
| rd_data | output | 8 | Channel byte read, registered |
| irq_mask | input | 1 | 1 hides the slip interrupt |
| irq_ack | input | 1 | Clears the pending slip interrupt |
| slip_tog | output | 1 | Inverts on every slip |
| slip_dir | output | 1 | Direction of the last slip: 1 repeat, 0 drop |
| slip_irq | output | 1 | Masked slip interrupt request |

## Verification
Frames are written and read at equal rates, which shows that data keeps its order at a steady distance of 32 and confirms the reset offset. Write bursts set the boundary distance to 3, 2, 0, 59, 60 and 63 in turn. Each pair of neighbouring values separates a threshold that is off by one from a correct one, and the repeated or skipped frame contents show which way the pointer moved. In a further pattern the read pointer passes the write pointer in the middle of a frame, which separates a slip that waits for channel 0 from one that reacts at once. The interrupt is also tested with the mask on, then with the mask off, and then after an acknowledge.

// File: rtl/esb_pkg.sv
// Package: shared sizes and the slip decision type of the receive elastic store.
// Assumes the channel count per frame and the frame count are powers of two.
package esb_pkg;
    localparam int CH_W_DEF      = 8;
    localparam int CH_FRAME_DEF  = 32;
    localparam int FRAMES_DEF    = 2;
    localparam int LOW_MARK_DEF  = 2;
    localparam int HIGH_MARK_DEF = 60;

    typedef enum logic [1:0] {
        SLIP_NONE   = 2'd0,
        SLIP_REPEAT = 2'd1,
        SLIP_DROP   = 2'd2
    } slip_kind_t;
endpackage

// File: rtl/esb_store.sv
// Module: dual-clock storage array. Write port on wclk, registered read port on rclk.
// Assumes the caller keeps the two addresses apart (the slip control guarantees a gap).
module esb_store #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store one channel byte per write strobe.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Register the addressed byte on each read strobe.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/esb_ptr_sync.sv
// Module: carries a binary pointer from the write clock into the read clock.
// Gray-encodes it in the source domain and passes it through two flops.
// Assumes the pointer changes by at most one step per source clock.
module esb_ptr_sync #(
    parameter int W = 6
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic [W-1:0] src_bin,
    input  logic         rclk,
    input  logic         rrst_n,
    output logic [W-1:0] dst_bin
);
    logic [W-1:0] gray_src;
    logic [W-1:0] gray_m1;
    logic [W-1:0] gray_m2;

    // Hold the Gray form of the pointer in a source-domain register.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            gray_src <= '0;
        end else begin
            gray_src <= src_bin ^ (src_bin >> 1);
        end
    end

    // Two-stage synchronizer into the read domain.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            gray_m1 <= '0;
            gray_m2 <= '0;
        end else begin
            gray_m1 <= gray_src;
            gray_m2 <= gray_m1;
        end
    end

    // Decode Gray back to binary, most significant bit first.
    always_comb begin
        dst_bin[W-1] = gray_m2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            dst_bin[i] = dst_bin[i+1] ^ gray_m2[i];
        end
    end
endmodule

// File: rtl/esb_slip_ctrl.sv
// Module: read pointer, distance measurement, frame slip decision and slip status.
// Assumes the write pointer input is already synchronized to rclk.
module esb_slip_ctrl
    import esb_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int CH_FRAME  = 32,
    parameter int LOW_MARK  = 2,
    parameter int HIGH_MARK = 60,
    localparam int AW       = $clog2(DEPTH),
    localparam int FW       = $clog2(CH_FRAME)
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] wptr_sync,
    input  logic          irq_mask,
    input  logic          irq_ack,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] rd_ptr,
    output logic          slip_tog,
    output logic          slip_dir,
    output logic          slip_irq
);
    localparam logic [AW-1:0] LOW_V   = AW'(LOW_MARK);
    localparam logic [AW-1:0] HIGH_V  = AW'(HIGH_MARK);
    localparam logic [AW-1:0] FRAME_V = AW'(CH_FRAME);
    localparam logic [AW-1:0] START_V = AW'(DEPTH - CH_FRAME);

    logic [AW-1:0] gap;
    logic          at_frame_start;
    slip_kind_t    kind;
    logic          irq_pend;

    // Measure the trailing distance and choose the slip for this read.
    always_comb begin
        gap            = wptr_sync - rd_ptr;
        at_frame_start = (rd_ptr[FW-1:0] == '0);
        kind           = SLIP_NONE;
        if (rd_en && at_frame_start) begin
            if (gap <= LOW_V) begin
                kind = SLIP_REPEAT;
            end else if (gap >= HIGH_V) begin
                kind = SLIP_DROP;
            end
        end
    end

    // Select the address actually read after any frame step.
    always_comb begin
        unique case (kind)
            SLIP_REPEAT: rd_addr = rd_ptr - FRAME_V;
            SLIP_DROP:   rd_addr = rd_ptr + FRAME_V;
            default:     rd_addr = rd_ptr;
        endcase
    end

    // Advance the read pointer past the channel just read.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rd_ptr <= START_V;
        end else if (rd_en) begin
            rd_ptr <= rd_addr + 1'b1;
        end
    end

    // Record the toggle and direction of each slip.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            slip_tog <= 1'b0;
            slip_dir <= 1'b0;
        end else if (kind != SLIP_NONE) begin
            slip_tog <= ~slip_tog;
            slip_dir <= (kind == SLIP_REPEAT);
        end
    end

    // Keep the interrupt pending until acknowledged; a new slip wins.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            irq_pend <= 1'b0;
        end else if (kind != SLIP_NONE) begin
            irq_pend <= 1'b1;
        end else if (irq_ack) begin
            irq_pend <= 1'b0;
        end
    end

    assign slip_irq = irq_pend & ~irq_mask;
endmodule

// File: rtl/rx_elastic_slip.sv
// Module: top of the receive elastic store. It owns the write pointer and joins
// the storage, the pointer crossing and the slip control.
// Assumes wclk and rclk are independent and each reset is held for several of its own cycles.
module rx_elastic_slip
    import esb_pkg::*;
#(
    parameter int CH_W      = CH_W_DEF,
    parameter int CH_FRAME  = CH_FRAME_DEF,
    parameter int FRAMES    = FRAMES_DEF,
    parameter int LOW_MARK  = LOW_MARK_DEF,
    parameter int HIGH_MARK = HIGH_MARK_DEF,
    localparam int DEPTH    = CH_FRAME * FRAMES,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic            wclk,
    input  logic            wrst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_data,
    input  logic            rclk,
    input  logic            rrst_n,
    input  logic            rd_en,
    output logic [CH_W-1:0] rd_data,
    input  logic            irq_mask,
    input  logic            irq_ack,
    output logic            slip_tog,
    output logic            slip_dir,
    output logic            slip_irq
);
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] wptr_sync;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] rd_ptr;

    // Advance the write pointer once per written channel.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    esb_store #(.W(CH_W), .DEPTH(DEPTH)) u_store (
        .wclk   (wclk),
        .we     (wr_en),
        .waddr  (wr_ptr),
        .wdata  (wr_data),
        .rclk   (rclk),
        .rrst_n (rrst_n),
        .re     (rd_en),
        .raddr  (rd_addr),
        .rdata  (rd_data)
    );

    esb_ptr_sync #(.W(AW)) u_sync (
        .wclk    (wclk),
        .wrst_n  (wrst_n),
        .src_bin (wr_ptr),
        .rclk    (rclk),
        .rrst_n  (rrst_n),
        .dst_bin (wptr_sync)
    );

    esb_slip_ctrl #(
        .DEPTH     (DEPTH),
        .CH_FRAME  (CH_FRAME),
        .LOW_MARK  (LOW_MARK),
        .HIGH_MARK (HIGH_MARK)
    ) u_ctrl (
        .rclk      (rclk),
        .rrst_n    (rrst_n),
        .rd_en     (rd_en),
        .wptr_sync (wptr_sync),
        .irq_mask  (irq_mask),
        .irq_ack   (irq_ack),
        .rd_addr   (rd_addr),
        .rd_ptr    (rd_ptr),
        .slip_tog  (slip_tog),
        .slip_dir  (slip_dir),
        .slip_irq  (slip_irq)
    );
endmodule

// File: rtl/esb_chk.sv
// Module: read-domain checker for the elastic store, bound to the top module.
// Assumes rrst_n is held low before the first rclk edge.
module esb_chk #(
    parameter int AW        = 6,
    parameter int FW        = 5,
    parameter int LOW_MARK  = 2,
    parameter int HIGH_MARK = 60
) (
    input logic          rclk,
    input logic          rrst_n,
    input logic          rd_en,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] wptr_sync,
    input logic          slip_tog,
    input logic          slip_dir,
    input logic          slip_irq,
    input logic          irq_mask
);
    logic [AW-1:0] gap_seen;
    assign gap_seen = wptr_sync - rd_ptr;

    // R7
    slip_on_boundary_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        (slip_tog != $past(slip_tog)) |-> ($past(rd_en) && ($past(rd_ptr[FW-1:0]) == '0)));

    // R4
    repeat_window_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        ((slip_tog != $past(slip_tog)) && slip_dir) |-> ($past(gap_seen) <= AW'(LOW_MARK)));

    // R5
    drop_window_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        ((slip_tog != $past(slip_tog)) && !slip_dir) |-> ($past(gap_seen) >= AW'(HIGH_MARK)));

    // R2
    ptr_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        !$past(rd_en) |-> ($stable(rd_ptr) && $stable(slip_tog)));

    // R3
    ptr_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        ($past(rd_en) && (slip_tog == $past(slip_tog))) |-> (rd_ptr == AW'($past(rd_ptr) + 1'b1)));

    // R10
    irq_hidden_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        irq_mask |-> !slip_irq);
endmodule

bind rx_elastic_slip esb_chk #(
    .AW        (AW),
    .FW        ($clog2(CH_FRAME)),
    .LOW_MARK  (LOW_MARK),
    .HIGH_MARK (HIGH_MARK)
) u_esb_chk (
    .rclk      (rclk),
    .rrst_n    (rrst_n),
    .rd_en     (rd_en),
    .rd_ptr    (rd_ptr),
    .wptr_sync (wptr_sync),
    .slip_tog  (slip_tog),
    .slip_dir  (slip_dir),
    .slip_irq  (slip_irq),
    .irq_mask  (irq_mask)
);

// File: tb/rx_elastic_slip_test.sv
// Bench: scoreboard for the receive elastic store. The read driver predicts each
// read from a requirement-level model and queues it; a monitor compares.
module rx_elastic_slip_test;
    localparam int CLK_PERIOD = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD + 4;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       wrst_n = 1'b0;
    logic       rrst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq_mask = 1'b0;
    logic       irq_ack = 1'b0;
    logic       slip_tog;
    logic       slip_dir;
    logic       slip_irq;

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    rx_elastic_slip uut (
        .wclk     (wclk),
        .wrst_n   (wrst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rclk     (rclk),
        .rrst_n   (rrst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .irq_mask (irq_mask),
        .irq_ack  (irq_ack),
        .slip_tog (slip_tog),
        .slip_dir (slip_dir),
        .slip_irq (slip_irq)
    );

    typedef struct {
        logic [7:0] data;
        bit         known;
        bit         tog;
        bit         dir;
        string      tag;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   n_chk = 0;
    int   n_bad = 0;

    // requirement-level model
    logic [7:0] m_mem [64];
    bit         m_known [64];
    int         m_wp = 0;
    int         m_rp = 32;
    bit         m_tog = 0;
    bit         m_dir = 0;
    logic [7:0] pat = 8'h11;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en = 1'b1;
            wr_data = pat;
            m_mem[m_wp] = pat;
            m_known[m_wp] = 1'b1;
            m_wp = (m_wp + 1) % 64;
            pat = pat + 8'd37;
        end
        @(negedge wclk);
        wr_en = 1'b0;
        repeat (8) @(negedge rclk);
    endtask

    task automatic rd_frame(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int   d;
            e.tag = "R2";
            if (m_rp % 32 == 0) begin
                d = (m_wp - m_rp) & 63;
                e.tag = "R6";
                if (d <= 2) begin
                    m_rp = m_rp ^ 32; m_tog = ~m_tog; m_dir = 1'b1; e.tag = "R4/R8/R9";
                end else if (d >= 60) begin
                    m_rp = m_rp ^ 32; m_tog = ~m_tog; m_dir = 1'b0; e.tag = "R5/R8/R9";
                end
            end else begin
                e.tag = "R7";
            end
            e.data  = m_mem[m_rp];
            e.known = m_known[m_rp];
            e.tog   = m_tog;
            e.dir   = m_dir;
            m_rp = (m_rp + 1) % 64;
            sb.push_back(e);
            @(negedge rclk);
            rd_en = 1'b1;
        end
        @(negedge rclk);
        rd_en = 1'b0;
        @(negedge rclk);
    endtask

    // write until the boundary distance seen by the next read equals target (R3)
    task automatic set_gap(input int target);
        int d;
        d = (m_wp - m_rp) & 63;
        wr_burst((target - d) & 63);
    endtask

    task automatic ack_irq();
        @(negedge rclk);
        irq_ack = 1'b1;
        @(negedge rclk);
        irq_ack = 1'b0;
    endtask

    // Monitor: pop the prediction for each read and compare after the edge.
    always @(posedge rclk) begin
        if (rrst_n === 1'b1 && rd_en === 1'b1) begin
            if (sb.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R2 unexpected read: actual=read expected=none");
            end else begin
                cur = sb.pop_front();
                #1;
                n_chk++;
                if ((cur.known && rd_data !== cur.data) || slip_tog !== cur.tog || slip_dir !== cur.dir) begin
                    n_bad++;
                    $display("FAIL %s actual=%0h/%0b/%0b expected=%0h/%0b/%0b", cur.tag,
                             rd_data, slip_tog, slip_dir, cur.data, cur.tog, cur.dir);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) m_known[i] = 1'b0;
        repeat (5) @(negedge rclk);
        wrst_n = 1'b1;
        rrst_n = 1'b1;
        @(negedge rclk);
        // R1: reset values
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 slip_tog", {7'd0, slip_tog}, 8'h00);
        check("R1 slip_dir", {7'd0, slip_dir}, 8'h00);
        check("R1 slip_irq", {7'd0, slip_irq}, 8'h00);
        // R1: first frame boundary sees distance 32, no slip
        rd_frame(32);
        // steady equal-rate traffic (R2, R6)
        for (int f = 0; f < 3; f++) begin
            wr_burst(32);
            rd_frame(32);
        end
        check("R1 no slip at start", {7'd0, slip_tog}, 8'h00);
        // R6 lower edge: 3 does not slip
        set_gap(3);
        rd_frame(32);
        // R4 at 2, interrupt masked (R10)
        irq_mask = 1'b1;
        set_gap(2);
        rd_frame(32);
        #1;
        check("R10 masked irq", {7'd0, slip_irq}, 8'h00);
        check("R8 toggle after repeat", {7'd0, slip_tog}, 8'h01);
        check("R9 repeat direction", {7'd0, slip_dir}, 8'h01);
        irq_mask = 1'b0;
        #1;
        check("R10 unmasked pending", {7'd0, slip_irq}, 8'h01);
        ack_irq();
        #1;
        check("R10 ack clears", {7'd0, slip_irq}, 8'h00);
        // R4 at 0
        set_gap(0);
        rd_frame(32);
        // R6 upper edge: 59 does not slip
        set_gap(59);
        rd_frame(32);
        ack_irq();
        #1;
        check("R10 cleared before drop", {7'd0, slip_irq}, 8'h00);
        // R5 at 60
        set_gap(60);
        rd_frame(32);
        #1;
        check("R5 drop direction", {7'd0, slip_dir}, 8'h00);
        check("R10 irq after drop", {7'd0, slip_irq}, 8'h01);
        ack_irq();
        // R5 at 63
        set_gap(63);
        rd_frame(32);
        // R7: reads pass the write pointer mid-frame, no slip until channel 0
        set_gap(20);
        rd_frame(32);
        rd_frame(32);
        // back to steady traffic
        set_gap(32);
        rd_frame(32);
        repeat (4) @(negedge rclk);
        check("R2 scoreboard drained", 8'(sb.size()), 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule